// File: doc/BRIEF.md
# Dual Clock Start/Stop Controller

This block handles the start and stop requests for two clocks on a chip: a fast clock and a slow clock. Software writes single-cycle task registers on a small register bus to ask for a clock to start or stop. Each clock has its own sequencer that moves through off, ramping-up, on and ramping-down states. The time spent ramping in each direction is a parameterised number of cycles. A run-request output for each clock tells the clock generator outside the block whether that clock is wanted.

When a clock finishes ramping up, its status register shows it running together with its source code, and a ready event flag is set. A level interrupt is high while any event flag is set and its enable bit is set. For the slow clock, software selects a source code. The block copies that code when the slow clock is started and reports the copy once the clock is up.

Top module: `dual_osc_sequencer`

## Requirements
- R1: After reset, both clocks are off. Run requests, status registers, event flags, the enable mask, the source select and the source copy are all 0, and irqOut is low.
- R2: A fast-clock start task is accepted only when the fast clock is off or ramping down. A stop task for either clock is accepted only when that clock is on or ramping up. Any other task write leaves state, request and status unchanged.
- R3: A slow-clock start task is accepted in every state. When the slow clock is on, a start restarts the ramp-up, and the ready event is raised again when that ramp-up completes.
- R4: The run request (hfReqOut / lfReqOut, and registers 8 / 9 bit 0) goes to 1 in the cycle after an accepted start and to 0 in the cycle after an accepted stop. It is 1 whenever the clock is on.
- R5: An accepted start completes START_CYC cycles later. The clock is then on, its status bit 0 is 1, its source field is set, and its event flag (register 4 for the fast clock, register 5 for the slow clock, bit 0) is set.
- R6: An accepted stop completes STOP_CYC cycles later. Fast-clock status (register 10) then reads 0. Slow-clock status (register 11) clears only bit 0 and keeps its source field in bits [SRC_W:1].
- R7: An accepted slow-clock start copies the source select (register 12) into the source copy (register 13). On completion, the copy appears in bits [SRC_W:1] of register 11. Later writes to the select do not change the status.
- R8: irqOut is high exactly when (event0 and enable bit 0) or (event1 and enable bit 1) holds. Enable bit 0 belongs to the fast clock and bit 1 to the slow clock.
- R9: Writing to register 6 ORs data bits [1:0] into the enable mask. Writing to register 7 clears the mask bits where data bits [1:0] are 1. Both registers read back the mask in bits [1:0].
- R10: Writing 0 to bit 0 of an event register clears that flag, and writing 1 has no effect. If hardware sets a flag in the same cycle that software clears it, the flag is set. Task registers 0 (fast on), 1 (fast off), 2 (slow on) and 3 (slow off) act on data bit 0 = 1 and always read 0.
- R11: An accepted task during a pending ramp cancels the pending completion and starts the new ramp's full count.
- R12: Writes take effect at the clock edge where regWe is high, and reads are combinational from regAddr. Register 12 holds SRC_W bits. Addresses 14 and 15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr |
| irqOut | output | 1 | Level interrupt |
| hfReqOut | output | 1 | Fast-clock run request |
| lfReqOut | output | 1 | Slow-clock run request |

## Verification
The bench sets the ramp lengths to 3 and 2 cycles for the fast clock and 4 and 2 cycles for the slow clock. With ramps longer than one cycle, a task can be written while a ramp is still pending. This makes the cancel-and-restart rule reachable, along with stops issued during ramp-up and starts issued during ramp-down. Because the two clocks use different lengths, a swapped parameter or a counter that loads the wrong value shows up as a completion in the wrong cycle. The fast-clock source code is set to 1, so the source field of the fast-clock status is nonzero and can be checked.

// File: rtl/osc_seq_pkg.sv
`timescale 1ns/1ps
package osc_seq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_HF_ON   = 4'd0;
  localparam logic [ADDR_W-1:0] A_HF_OFF  = 4'd1;
  localparam logic [ADDR_W-1:0] A_LF_ON   = 4'd2;
  localparam logic [ADDR_W-1:0] A_LF_OFF  = 4'd3;
  localparam logic [ADDR_W-1:0] A_HF_EVT  = 4'd4;
  localparam logic [ADDR_W-1:0] A_LF_EVT  = 4'd5;
  localparam logic [ADDR_W-1:0] A_EN_SET  = 4'd6;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 4'd7;
  localparam logic [ADDR_W-1:0] A_HF_REQ  = 4'd8;
  localparam logic [ADDR_W-1:0] A_LF_REQ  = 4'd9;
  localparam logic [ADDR_W-1:0] A_HF_STAT = 4'd10;
  localparam logic [ADDR_W-1:0] A_LF_STAT = 4'd11;
  localparam logic [ADDR_W-1:0] A_LF_SEL  = 4'd12;
  localparam logic [ADDR_W-1:0] A_LF_COPY = 4'd13;

  typedef enum logic [1:0] {
    OSC_OFF       = 2'd0,
    OSC_RAMP_UP   = 2'd1,
    OSC_ON        = 2'd2,
    OSC_RAMP_DOWN = 2'd3
  } oscState_t;

  // task pulses from the register decode to one sequencer
  typedef struct packed {
    logic on;
    logic off;
  } oscCmd_t;

  // strobes from one sequencer to the register datapath
  typedef struct packed {
    logic reqSet;
    logic reqClr;
    logic upDone;
    logic downDone;
  } oscStrobe_t;
endpackage

// File: rtl/osc_seq_fsm.sv
`timescale 1ns/1ps
module osc_seq_fsm
  import osc_seq_pkg::*;
#(
  parameter int START_CYC = 1,
  parameter int STOP_CYC = 1,
  parameter bit RESTART_ON_START = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  oscCmd_t    cmd,
  output oscStrobe_t strb,
  output oscState_t  state
);
  localparam int MAX_CYC = (START_CYC > STOP_CYC) ? START_CYC : STOP_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] UP_LOAD = CNT_W'(START_CYC - 1);
  localparam logic [CNT_W-1:0] DN_LOAD = CNT_W'(STOP_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic startOk, stopOk, cntZero;

  always_comb begin
    startOk = cmd.on && (RESTART_ON_START || state == OSC_OFF || state == OSC_RAMP_DOWN);
    stopOk = cmd.off && (state == OSC_ON || state == OSC_RAMP_UP);
    cntZero = (cnt == '0);
    strb.reqSet = startOk;
    strb.reqClr = stopOk;
    strb.upDone = !startOk && !stopOk && state == OSC_RAMP_UP && cntZero;
    strb.downDone = !startOk && !stopOk && state == OSC_RAMP_DOWN && cntZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= OSC_OFF;
      cnt <= '0;
    end else if (startOk) begin
      state <= OSC_RAMP_UP;
      cnt <= UP_LOAD;
    end else if (stopOk) begin
      state <= OSC_RAMP_DOWN;
      cnt <= DN_LOAD;
    end else if (strb.upDone) begin
      state <= OSC_ON;
    end else if (strb.downDone) begin
      state <= OSC_OFF;
    end else if (state == OSC_RAMP_UP || state == OSC_RAMP_DOWN) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/osc_seq_ctrl.sv
`timescale 1ns/1ps
module osc_seq_ctrl
  import osc_seq_pkg::*;
#(
  parameter int HF_START_CYC = 1,
  parameter int HF_STOP_CYC = 1,
  parameter int LF_START_CYC = 1,
  parameter int LF_STOP_CYC = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  oscCmd_t    [1:0] cmd,
  output oscStrobe_t [1:0] strb,
  output oscState_t        hfState,
  output oscState_t        lfState
);
  oscState_t st [2];

  // index 0 is the fast clock, index 1 the slow clock (restartable)
  for (genvar i = 0; i < 2; i++) begin : g_osc
    localparam int UP_CYC = (i == 0) ? HF_START_CYC : LF_START_CYC;
    localparam int DN_CYC = (i == 0) ? HF_STOP_CYC : LF_STOP_CYC;
    osc_seq_fsm #(
      .START_CYC(UP_CYC),
      .STOP_CYC(DN_CYC),
      .RESTART_ON_START(i == 1)
    ) u_fsm (
      .clk(clk),
      .rstN(rstN),
      .cmd(cmd[i]),
      .strb(strb[i]),
      .state(st[i])
    );
  end

  assign hfState = st[0];
  assign lfState = st[1];
endmodule

// File: rtl/osc_seq_regs.sv
`timescale 1ns/1ps
module osc_seq_regs
  import osc_seq_pkg::*;
#(
  parameter int SRC_W = 2,
  parameter logic [SRC_W-1:0] HF_SRC_CODE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  oscStrobe_t  [1:0] strb,
  output oscCmd_t     [1:0] cmd,
  output logic        [1:0] evtFlags,
  output logic              irqOut,
  output logic              hfReqOut,
  output logic              lfReqOut
);
  logic [1:0] runReq, running, enMask;
  logic [SRC_W-1:0] statSrc [2];
  logic [SRC_W-1:0] srcSel, srcCopy;
  logic unusedWdata;

  assign unusedWdata = ^regWdata[DATA_W-1:2];

  for (genvar i = 0; i < 2; i++) begin : g_clk
    localparam logic [ADDR_W-1:0] ON_ADDR = A_HF_ON + ADDR_W'(2 * i);
    localparam logic [ADDR_W-1:0] OFF_ADDR = A_HF_OFF + ADDR_W'(2 * i);
    localparam logic [ADDR_W-1:0] EVT_ADDR = A_HF_EVT + ADDR_W'(i);

    assign cmd[i].on = regWe && regAddr == ON_ADDR && regWdata[0];
    assign cmd[i].off = regWe && regAddr == OFF_ADDR && regWdata[0];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runReq[i] <= 1'b0;
        running[i] <= 1'b0;
        evtFlags[i] <= 1'b0;
      end else begin
        if (strb[i].reqSet) runReq[i] <= 1'b1;
        else if (strb[i].reqClr) runReq[i] <= 1'b0;
        if (strb[i].upDone) running[i] <= 1'b1;
        else if (strb[i].downDone) running[i] <= 1'b0;
        if (strb[i].upDone) evtFlags[i] <= 1'b1;
        else if (regWe && regAddr == EVT_ADDR && !regWdata[0]) evtFlags[i] <= 1'b0;
      end
    end

    if (i == 0) begin : g_fast_src
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) statSrc[i] <= '0;
        else if (strb[i].upDone) statSrc[i] <= HF_SRC_CODE;
        else if (strb[i].downDone) statSrc[i] <= '0;
      end
    end else begin : g_slow_src
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) statSrc[i] <= '0;
        else if (strb[i].upDone) statSrc[i] <= srcCopy;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask <= '0;
      srcSel <= '0;
      srcCopy <= '0;
    end else begin
      if (regWe && regAddr == A_EN_SET) enMask <= enMask | regWdata[1:0];
      if (regWe && regAddr == A_EN_CLR) enMask <= enMask & ~regWdata[1:0];
      if (regWe && regAddr == A_LF_SEL) srcSel <= regWdata[SRC_W-1:0];
      if (strb[1].reqSet) srcCopy <= srcSel;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_HF_EVT:  regRdata[0] = evtFlags[0];
      A_LF_EVT:  regRdata[0] = evtFlags[1];
      A_EN_SET,
      A_EN_CLR:  regRdata[1:0] = enMask;
      A_HF_REQ:  regRdata[0] = runReq[0];
      A_LF_REQ:  regRdata[0] = runReq[1];
      A_HF_STAT: regRdata[SRC_W:0] = {statSrc[0], running[0]};
      A_LF_STAT: regRdata[SRC_W:0] = {statSrc[1], running[1]};
      A_LF_SEL:  regRdata[SRC_W-1:0] = srcSel;
      A_LF_COPY: regRdata[SRC_W-1:0] = srcCopy;
      default:   regRdata = '0;
    endcase
  end

  assign irqOut = |(evtFlags & enMask);
  assign hfReqOut = runReq[0];
  assign lfReqOut = runReq[1];
endmodule

// File: rtl/dual_osc_sequencer.sv
`timescale 1ns/1ps
module dual_osc_sequencer
  import osc_seq_pkg::*;
#(
  parameter int HF_START_CYC = 1,
  parameter int HF_STOP_CYC = 1,
  parameter int LF_START_CYC = 1,
  parameter int LF_STOP_CYC = 1,
  parameter int SRC_W = 2,
  parameter logic [SRC_W-1:0] HF_SRC_CODE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut,
  output logic              hfReqOut,
  output logic              lfReqOut
);
  oscCmd_t    [1:0] cmd;
  oscStrobe_t [1:0] strb;
  oscState_t        hfState, lfState;
  logic       [1:0] evtFlags;

  osc_seq_ctrl #(
    .HF_START_CYC(HF_START_CYC),
    .HF_STOP_CYC(HF_STOP_CYC),
    .LF_START_CYC(LF_START_CYC),
    .LF_STOP_CYC(LF_STOP_CYC)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .cmd(cmd),
    .strb(strb),
    .hfState(hfState),
    .lfState(lfState)
  );

  osc_seq_regs #(
    .SRC_W(SRC_W),
    .HF_SRC_CODE(HF_SRC_CODE)
  ) u_regs (
    .clk(clk),
    .rstN(rstN),
    .regWe(regWe),
    .regAddr(regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .strb(strb),
    .cmd(cmd),
    .evtFlags(evtFlags),
    .irqOut(irqOut),
    .hfReqOut(hfReqOut),
    .lfReqOut(lfReqOut)
  );
endmodule

// File: rtl/osc_seq_checker.sv
`timescale 1ns/1ps
module osc_seq_checker
  import osc_seq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrBit0,
  input logic              irqOut,
  input logic              hfReqOut,
  input logic              lfReqOut,
  input oscState_t         hfState,
  input oscState_t         lfState,
  input logic        [1:0] evtFlags
);
  assert_hf_start_sets_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_HF_ON && wrBit0 && (hfState == OSC_OFF || hfState == OSC_RAMP_DOWN))
    |=> hfReqOut);

  assert_lf_stop_clears_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_LF_OFF && wrBit0 && (lfState == OSC_ON || lfState == OSC_RAMP_UP))
    |=> !lfReqOut);

  assert_on_has_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hfState == OSC_ON) |-> hfReqOut);

  assert_lf_on_has_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lfState == OSC_ON) |-> lfReqOut);

  assert_hf_start_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hfState == OSC_ON && regWe && regAddr == A_HF_ON) |=> (hfState == OSC_ON));

  assert_hf_evt_when_on_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtFlags[0]) |-> (hfState == OSC_ON));

  assert_lf_evt_when_on_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtFlags[1]) |-> (lfState == OSC_ON));

  assert_irq_falls_on_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(regWe));
endmodule

bind dual_osc_sequencer osc_seq_checker i_chk (
  .clk(clk),
  .rstN(rstN),
  .regWe(regWe),
  .regAddr(regAddr),
  .wrBit0(regWdata[0]),
  .irqOut(irqOut),
  .hfReqOut(hfReqOut),
  .lfReqOut(lfReqOut),
  .hfState(hfState),
  .lfState(lfState),
  .evtFlags(evtFlags)
);

// File: tb/test_dual_osc_sequencer.sv
`timescale 1ns/1ps
module test_dual_osc_sequencer;
  localparam int HS = 3, HP = 2, LS = 4, LP = 2;
  localparam logic [1:0] HSRC = 2'd1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic irqOut, hfReqOut, lfReqOut;

  always #2.5 clk = ~clk;

  dual_osc_sequencer #(
    .HF_START_CYC(HS), .HF_STOP_CYC(HP), .LF_START_CYC(LS), .LF_STOP_CYC(LP),
    .SRC_W(2), .HF_SRC_CODE(HSRC)
  ) i_dual_osc_sequencer (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut), .hfReqOut(hfReqOut), .lfReqOut(lfReqOut)
  );

  int checks = 0, fails = 0;
  string phaseTag = "";
  bit finished = 1'b0;

  // reference model: 0 off, 1 ramp up, 2 on, 3 ramp down
  int mSt [2];
  int mCnt [2];
  bit mReq [2], mRun [2], mEvt [2], mEn [2];
  bit [1:0] mStatSrc [2];
  bit [1:0] mSel, mCopy;

  task automatic mReset();
    for (int i = 0; i < 2; i++) begin
      mSt[i] = 0; mCnt[i] = 0; mReq[i] = 0; mRun[i] = 0; mEvt[i] = 0; mEn[i] = 0; mStatSrc[i] = 0;
    end
    mSel = 0; mCopy = 0;
  endtask

  task automatic mStep();
    bit we, b0, on, off, okOn, okOff;
    int a;
    we = regWe; a = int'(regAddr); b0 = regWdata[0];
    for (int i = 0; i < 2; i++) begin
      on = we && a == 2 * i && b0;
      off = we && a == 2 * i + 1 && b0;
      okOn = on && (i == 1 || mSt[i] == 0 || mSt[i] == 3);
      okOff = off && (mSt[i] == 2 || mSt[i] == 1);
      if (we && a == 4 + i && !b0) mEvt[i] = 0;
      if (okOn) begin
        mSt[i] = 1; mCnt[i] = ((i == 0) ? HS : LS) - 1; mReq[i] = 1;
        if (i == 1) mCopy = mSel;
      end else if (okOff) begin
        mSt[i] = 3; mCnt[i] = ((i == 0) ? HP : LP) - 1; mReq[i] = 0;
      end else if (mSt[i] == 1) begin
        if (mCnt[i] == 0) begin
          mSt[i] = 2; mRun[i] = 1; mStatSrc[i] = (i == 0) ? HSRC : mCopy; mEvt[i] = 1;
        end else mCnt[i]--;
      end else if (mSt[i] == 3) begin
        if (mCnt[i] == 0) begin
          mSt[i] = 0; mRun[i] = 0;
          if (i == 0) mStatSrc[i] = 0;
        end else mCnt[i]--;
      end
    end
    if (we && a == 6) begin mEn[0] |= regWdata[0]; mEn[1] |= regWdata[1]; end
    if (we && a == 7) begin
      if (regWdata[0]) mEn[0] = 0;
      if (regWdata[1]) mEn[1] = 0;
    end
    if (we && a == 12) mSel = regWdata[1:0];
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) mReset();
    else mStep();
  end

  function automatic logic [31:0] mRead(logic [3:0] a);
    case (a)
      4'd4: return {31'b0, mEvt[0]};
      4'd5: return {31'b0, mEvt[1]};
      4'd6, 4'd7: return {30'b0, mEn[1], mEn[0]};
      4'd8: return {31'b0, mReq[0]};
      4'd9: return {31'b0, mReq[1]};
      4'd10: return {29'b0, mStatSrc[0], mRun[0]};
      4'd11: return {29'b0, mStatSrc[1], mRun[1]};
      4'd12: return {30'b0, mSel};
      4'd13: return {30'b0, mCopy};
      default: return 32'b0;
    endcase
  endfunction

  function automatic string addrTag(logic [3:0] a);
    if (phaseTag != "") return phaseTag;
    case (a)
      4'd0, 4'd1, 4'd2, 4'd3: return "R10";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd7: return "R9";
      4'd8, 4'd9: return "R4";
      4'd10: return "R6";
      4'd11, 4'd13: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    bit expIrq;
    expIrq = (mEvt[0] && mEn[0]) || (mEvt[1] && mEn[1]);
    chk((phaseTag != "") ? phaseTag : "R4", {31'b0, hfReqOut}, {31'b0, mReq[0]});
    chk((phaseTag != "") ? phaseTag : "R4", {31'b0, lfReqOut}, {31'b0, mReq[1]});
    chk((phaseTag != "") ? phaseTag : "R8", {31'b0, irqOut}, {31'b0, expIrq});
    chk(addrTag(regAddr), regRdata, mRead(regAddr));
  endtask

  task automatic cyc(bit we, int a, logic [31:0] d);
    @(negedge clk);
    checkAll();
    regWe = we; regAddr = 4'(a); regWdata = d;
  endtask

  task automatic idle(int n, int a);
    for (int k = 0; k < n; k++) cyc(1'b0, a, 32'b0);
  endtask

  initial begin
    int seedDummy;
    int r;
    seedDummy = $urandom(32'h0005eed5);
    mReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    phaseTag = "R1";
    for (int a = 0; a < 16; a++) cyc(1'b0, a, 32'b0);
    phaseTag = "R5";
    cyc(1'b1, 6, 32'h3);
    cyc(1'b1, 0, 32'h1);
    idle(5, 10);
    idle(1, 4);
    phaseTag = "R2";
    cyc(1'b1, 0, 32'h1);
    idle(2, 10);
    cyc(1'b1, 3, 32'h1);
    idle(2, 11);
    phaseTag = "R7";
    cyc(1'b1, 12, 32'h2);
    cyc(1'b1, 2, 32'h1);
    cyc(1'b1, 12, 32'h3);
    idle(5, 11);
    idle(1, 13);
    phaseTag = "R3";
    cyc(1'b1, 5, 32'h0);
    cyc(1'b1, 2, 32'h1);
    idle(6, 11);
    idle(1, 5);
    phaseTag = "R10";
    cyc(1'b1, 4, 32'h0);
    cyc(1'b1, 4, 32'h1);
    idle(1, 4);
    idle(1, 0);
    phaseTag = "R11";
    cyc(1'b1, 1, 32'h1);
    cyc(1'b1, 0, 32'h1);
    idle(5, 10);
    cyc(1'b1, 1, 32'h1);
    idle(1, 10);
    cyc(1'b1, 0, 32'h1);
    idle(4, 10);
    phaseTag = "R6";
    cyc(1'b1, 1, 32'h1);
    idle(3, 10);
    cyc(1'b1, 3, 32'h1);
    idle(3, 11);
    phaseTag = "R9";
    cyc(1'b1, 7, 32'h1);
    idle(1, 6);
    idle(1, 7);
    phaseTag = "R12";
    cyc(1'b1, 12, 32'h1);
    idle(1, 12);
    idle(1, 15);
    phaseTag = "";
    for (int n = 0; n < 4000; n++) begin
      r = int'($urandom % 100);
      if (r < 55) begin
        logic [31:0] d;
        d = $urandom;
        if (r < 35) d[0] = 1'b1;
        cyc(1'b1, int'($urandom % 14), d);
      end else begin
        cyc(1'b0, int'($urandom % 16), 32'b0);
      end
    end
    idle(1, 0);
    @(negedge clk);
    checkAll();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R12 watchdog act=running exp=finished t=%0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule